// File: doc/BRIEF.md
# Video lock status hysteresis filter

This block sits behind the raw lock detectors of a video decoder. It turns a per-line lock hint into a lock status that does not flicker. Once per video line, marked by a one-cycle line strobe, it samples one of two raw sources.

- The fast source follows horizontal sync from one line to the next.
- The slow source judges the signal across several fields and also uses vertical sync.

The filter has two states, unlocked and locked. While unlocked, it counts consecutive lines on which the chosen source reports lock. While locked, it counts consecutive lines on which the source reports no lock. It changes state only when the count reaches a line threshold chosen by a 3-bit code. The code for entering lock and the code for leaving lock are separate, so the entry and exit delays can differ. Between transitions the state is held.

A second output qualifies the filtered lock with a color subcarrier lock flag. A configuration bit can turn this qualification off.

The configuration byte comes from a register elsewhere. That register should reset to 8'hA4: slow source selected, both codes 3'b100 (100 lines), subcarrier qualification on.

Top module: `lock_status_filter`

## Requirements
- R1: While reset is asserted, and right after it, `hlock` and `qlock` are 0. The filter starts in the unlocked state with both line counts at zero.
- R2: `cfg[6]` selects the raw source sampled on each line. 0 selects `raw_slow` and 1 selects `raw_fast`. The other source has no effect on the state.
- R3: `cfg[2:0]` sets the entry threshold in lines. The codes 0 to 7 give 1, 2, 5, 10, 100, 500, 1000 and 100000. `hlock` rises after the line on which the count of consecutive lock lines reaches the entry threshold.
- R4: `cfg[5:3]` sets the exit threshold in lines, using the same code table. `hlock` falls after the line on which the count of consecutive no-lock lines reaches the exit threshold.
- R5: A single line with the opposite raw value clears the running count. Only unbroken runs of lines lead to a transition.
- R6: Lines are counted only on clock edges where `line_stb` is 1. `hlock` changes only in the cycle after such an edge, so raw inputs with no strobe change nothing.
- R7: With a threshold code of 0, one qualifying line causes the transition.
- R8: When `cfg[7]` is 1, `qlock` equals `hlock` AND `sc_lock`. When `cfg[7]` is 0, `qlock` equals `hlock`.
- R9: A configuration change does not alter the lock state until the next line strobe. If the new threshold is at or below the running count, the next qualifying line causes the transition.
- R10: A 100000-line threshold is counted exactly: 99999 lock lines leave the filter unlocked and the 100000th locks it. The counts saturate instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle strobe, one per video line |
| raw_slow | input | 1 | Raw lock from the multi-field evaluator |
| raw_fast | input | 1 | Raw lock from the line-to-line horizontal sync evaluator |
| sc_lock | input | 1 | Color subcarrier lock flag |
| cfg | input | 8 | [7] subcarrier qualify, [6] source select, [5:3] exit code, [2:0] entry code |
| hlock | output | 1 | Filtered horizontal lock (status bit 0) |
| qlock | output | 1 | Subcarrier-qualified lock (status bit 1) |

## Verification
The hardest case to reach is the largest threshold. The bench proves the 100000th line is the one that locks by holding the strobe high for 99999 consecutive cycles, checking, then applying one more line. A second hard case is lowering the entry threshold below a count already running. To reach it, the bench builds up 50 lock lines under the 100-line code, switches to the 10-line code with no strobe, and shows that the state stays put until the next line arrives.

// File: rtl/lock_filt_pkg.sv
package lock_filt_pkg;

  // Layout of the configuration byte (bit 7 down to bit 0).
  typedef struct packed {
    logic       qual_en;   // qualify with subcarrier lock
    logic       src_fast;  // 1: fast line-to-line source
    logic [2:0] exit_code;
    logic [2:0] entry_code;
  } lf_cfg_t;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lf_state_t;

  // Nonlinear code-to-line-count mapping.
  function automatic int unsigned code_to_lines(input logic [2:0] code);
    case (code)
      3'd0:    code_to_lines = 1;
      3'd1:    code_to_lines = 2;
      3'd2:    code_to_lines = 5;
      3'd3:    code_to_lines = 10;
      3'd4:    code_to_lines = 100;
      3'd5:    code_to_lines = 500;
      3'd6:    code_to_lines = 1000;
      default: code_to_lines = 100000;
    endcase
  endfunction

endpackage

// File: rtl/lock_src_select.sv
module lock_src_select (
  input  logic src_fast,
  input  logic raw_slow,
  input  logic raw_fast,
  output logic raw_sel
);
  always_comb begin
    if (src_fast) raw_sel = raw_fast;
    else          raw_sel = raw_slow;
  end
endmodule

// File: rtl/lock_thresh_decode.sv
module lock_thresh_decode #(
  parameter int CNT_W = 17
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] lines
);
  import lock_filt_pkg::*;

  always_comb begin
    lines = CNT_W'(code_to_lines(code));
  end
endmodule

// File: rtl/lock_line_counter.sv
module lock_line_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_inc
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Saturating increment: the next count never wraps.
  always_comb begin
    if (count == CNT_MAX) count_inc = CNT_MAX;
    else                  count_inc = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count_inc;
  end
endmodule

// File: rtl/lock_status_filter.sv
module lock_status_filter #(
  parameter int CNT_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       raw_slow,
  input  logic       raw_fast,
  input  logic       sc_lock,
  input  logic [7:0] cfg,
  output logic       hlock,
  output logic       qlock
);
  import lock_filt_pkg::*;

  localparam int NDIR     = 2;  // 0: entry count, 1: exit count
  localparam int DIR_IN   = 0;
  localparam int DIR_OUT  = 1;
  localparam int MAX_LINE = 100000;

  initial begin
    if ((64'd1 << CNT_W) <= 64'(MAX_LINE))
      $error("CNT_W too narrow for the largest threshold");
  end

  lf_cfg_t   cfg_s;
  lf_state_t state;
  logic      raw_sel;

  logic [CNT_W-1:0] thr   [NDIR];
  logic [CNT_W-1:0] cnt   [NDIR];
  logic [CNT_W-1:0] inc   [NDIR];
  logic             step  [NDIR];
  logic             clr   [NDIR];
  logic             hit   [NDIR];
  logic [2:0]       code  [NDIR];

  assign cfg_s = lf_cfg_t'(cfg);
  assign code[DIR_IN]  = cfg_s.entry_code;
  assign code[DIR_OUT] = cfg_s.exit_code;

  lock_src_select u_sel (
    .src_fast (cfg_s.src_fast),
    .raw_slow (raw_slow),
    .raw_fast (raw_fast),
    .raw_sel  (raw_sel)
  );

  // Per-direction qualification: the entry count runs while unlocked on
  // lock lines, the exit count runs while locked on no-lock lines.
  always_comb begin
    step[DIR_IN]  = line_stb && (state == ST_UNLOCKED) &&  raw_sel;
    step[DIR_OUT] = line_stb && (state == ST_LOCKED)   && !raw_sel;
    for (int d = 0; d < NDIR; d++) begin
      hit[d] = step[d] && (inc[d] >= thr[d]);
    end
    clr[DIR_IN]  = (state == ST_LOCKED)   || hit[DIR_IN]  || (line_stb && !raw_sel);
    clr[DIR_OUT] = (state == ST_UNLOCKED) || hit[DIR_OUT] || (line_stb &&  raw_sel);
  end

  for (genvar gd = 0; gd < NDIR; gd++) begin : g_dir
    lock_thresh_decode #(.CNT_W(CNT_W)) u_dec (
      .code  (code[gd]),
      .lines (thr[gd])
    );
    lock_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step[gd]),
      .clear     (clr[gd]),
      .count     (cnt[gd]),
      .count_inc (inc[gd])
    );
  end

  // Lock state memory.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            state <= ST_UNLOCKED;
    else if (hit[DIR_IN])  state <= ST_LOCKED;
    else if (hit[DIR_OUT]) state <= ST_UNLOCKED;
  end

  assign hlock = (state == ST_LOCKED);
  assign qlock = hlock && (!cfg_s.qual_en || sc_lock);

endmodule

// File: rtl/lock_status_filter_chk.sv
module lock_status_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_stb,
  input logic       raw_slow,
  input logic       raw_fast,
  input logic       sc_lock,
  input logic [7:0] cfg,
  input logic       hlock,
  input logic       qlock
);
  logic sel_ref;
  assign sel_ref = cfg[6] ? raw_fast : raw_slow;

  assert_reset_unlocked_R1: assert property (@(posedge clk)
    !rst_n |-> !hlock && !qlock);

  assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(hlock));

  assert_rise_on_lock_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlock) |-> $past(line_stb && sel_ref));

  assert_fall_on_nolock_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlock) |-> $past(line_stb && !sel_ref));

  assert_qual_needs_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    qlock |-> hlock && (sc_lock || !cfg[7]));

  assert_qual_off_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[7] |-> (qlock == hlock));

endmodule

bind lock_status_filter lock_status_filter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_stb (line_stb),
  .raw_slow (raw_slow),
  .raw_fast (raw_fast),
  .sc_lock  (sc_lock),
  .cfg      (cfg),
  .hlock    (hlock),
  .qlock    (qlock)
);

// File: tb/test_lock_status_filter.sv
module test_lock_status_filter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_stb;
  logic       raw_slow;
  logic       raw_fast;
  logic       sc_lock;
  logic [7:0] cfg;
  logic       hlock;
  logic       qlock;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam int WATCHDOG = 150000;

  always #2.5 clk = ~clk;  // 200 MHz

  lock_status_filter i_lock_status_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .raw_slow (raw_slow),
    .raw_fast (raw_fast),
    .sc_lock  (sc_lock),
    .cfg      (cfg),
    .hlock    (hlock),
    .qlock    (qlock)
  );

  typedef struct packed {
    logic [7:0]  cfg;
    logic        slow;
    logic        fast;
    logic        sc;
    logic [31:0] lines;
    logic        exp_h;
    logic        exp_q;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b1, 1'b0, 1'b0, 32'd1, 1'b1, 1'b1},  // R7 R2: one line locks
    '{8'h00, 1'b0, 1'b0, 1'b0, 32'd1, 1'b0, 1'b0},  // R7 R4: one line unlocks
    '{8'h01, 1'b1, 1'b0, 1'b0, 32'd1, 1'b0, 1'b0},  // R3: 1 of 2
    '{8'h01, 1'b1, 1'b0, 1'b0, 32'd1, 1'b1, 1'b1},  // R3: 2 of 2
    '{8'h50, 1'b0, 1'b1, 1'b0, 32'd3, 1'b1, 1'b1},  // R2: fast source high
    '{8'h50, 1'b1, 1'b0, 1'b0, 32'd4, 1'b1, 1'b1},  // R4: 4 of 5
    '{8'h50, 1'b1, 1'b0, 1'b0, 32'd1, 1'b0, 1'b0},  // R4 R2: 5 of 5
    '{8'h82, 1'b1, 1'b0, 1'b0, 32'd5, 1'b1, 1'b0},  // R8: sc low gates
    '{8'h82, 1'b1, 1'b0, 1'b1, 32'd0, 1'b1, 1'b1},  // R8: sc high
    '{8'h02, 1'b1, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1}   // R8: qualify off
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic run_lines(input int n);
    if (n > 0) begin
      line_stb = 1'b1;
      repeat (n) @(negedge clk);
      line_stb = 1'b0;
    end
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; line_stb = 1'b0; raw_slow = 1'b0; raw_fast = 1'b0;
    sc_lock = 1'b0; cfg = 8'hA4;
    repeat (3) @(negedge clk);
    check("R1 hlock in reset", hlock, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 hlock after reset", hlock, 1'b0);
    check("R1 qlock after reset", qlock, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cfg = VECS[i].cfg; raw_slow = VECS[i].slow; raw_fast = VECS[i].fast;
      sc_lock = VECS[i].sc;
      run_lines(int'(VECS[i].lines));
      check($sformatf("vector %0d hlock", i), hlock, VECS[i].exp_h);
      check($sformatf("vector %0d qlock", i), qlock, VECS[i].exp_q);
    end

    // R5: a broken run restarts the count (entry 10, exit 1)
    @(negedge clk);
    cfg = 8'h03; raw_slow = 1'b0; sc_lock = 1'b0;
    run_lines(1);
    check("R5 unlock first", hlock, 1'b0);
    raw_slow = 1'b1; run_lines(9);
    raw_slow = 1'b0; run_lines(1);
    raw_slow = 1'b1; run_lines(9);
    check("R5 broken run stays unlocked", hlock, 1'b0);
    run_lines(1);
    check("R5 tenth unbroken line locks", hlock, 1'b1);

    // R6: raw activity without strobe changes nothing; one strobe acts next cycle
    cfg = 8'h00; raw_slow = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check("R6 no strobe keeps lock", hlock, 1'b1);
    run_lines(1);
    check("R6 one strobe unlocks one cycle later", hlock, 1'b0);

    // R9: lowering entry threshold below a running count
    cfg = 8'h04; raw_slow = 1'b1;
    run_lines(50);
    check("R9 50 of 100 unlocked", hlock, 1'b0);
    cfg = 8'h03;
    repeat (5) @(negedge clk);
    #1;
    check("R9 config change alone keeps state", hlock, 1'b0);
    run_lines(1);
    check("R9 next line locks at new threshold", hlock, 1'b1);
    cfg = 8'h3F; raw_slow = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 config change keeps locked state", hlock, 1'b1);

    // R10: largest threshold counted exactly
    cfg = 8'h07; raw_slow = 1'b0;
    run_lines(1);
    check("R10 unlock before long run", hlock, 1'b0);
    raw_slow = 1'b1;
    run_lines(99999);
    check("R10 99999 lines unlocked", hlock, 1'b0);
    run_lines(1);
    check("R10 100000th line locks", hlock, 1'b1);

    // R1: reset while locked
    rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 reset clears lock", hlock, 1'b0);
    check("R1 reset clears qlock", qlock, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule